// File: doc/BRIEF.md
# SDRAM Power-Up Initialization Sequencer

This block runs the power-up command sequence for a bank of SDRAM rows. A single-cycle `init_start` pulse starts it. It then hands one command at a time to a separate row broadcaster, which sends that command to every populated row and reports back with `bcast_done`. After each acknowledged command the sequencer holds off for a programmed number of microseconds before it requests the next one.

The waits are measured in whole microseconds. A prescaler divides the clock by `CLKS_PER_US` to produce a one-microsecond tick, and a microsecond counter counts those ticks. The sequence runs in this order:

- a no-operation command with a long settling wait;
- a precharge of all banks;
- a fixed number of auto-refresh commands, each with its own wait;
- a mode-register load;
- a final switch to normal operation.

When the last wait expires, the block raises the refresh-enable flag and `init_done` together. Both stay high until reset. The CAS-latency select output gives the broadcaster the latency chosen at build time, so it can form the mode-register address pattern.

Top module: `sdram_pwrup_seq`

## Requirements
- R1: After a synchronous reset, the outputs are `bcast_req`=0, `cmd_code`=000, `refresh_en`=0 and `init_done`=0. Nothing is requested until an `init_start` pulse arrives; the first request appears in the cycle after that pulse is sampled.
- R2: One run issues 12 commands, in this order and with these codes: no-op 001, precharge-all 010, eight auto-refresh 100, mode-register load 011, normal operation 000.
- R3: `bcast_req` stays high, with `cmd_code` unchanged, until `bcast_done` is sampled high in the same cycle, and it drops in the following cycle. A `bcast_done` seen while no request is pending has no effect.
- R4: The waits after the commands are 200 µs (no-op), 1 µs (precharge), 1 µs (each refresh), 2 µs (mode load) and 1 µs (normal). For a command whose `bcast_done` is sampled in cycle n, the next request appears in cycle n + wait×`CLKS_PER_US` + 1.
- R5: Each wait is counted from the accepted `bcast_done`, not from the request. A run takes 212×`CLKS_PER_US` + 13 + 12×L cycles from the start pulse to `init_done`, where L is the broadcaster's acknowledge latency in cycles.
- R6: `refresh_en` and `init_done` rise in the same cycle, exactly 1×`CLKS_PER_US` + 1 cycles after the normal-operation command is acknowledged, and never earlier.
- R7: Once high, `init_done` and `refresh_en` stay high until reset, and no further request is made.
- R8: An `init_start` pulse while the sequence is running, or after it has completed, is ignored.
- R9: `cas_sel` is 1 when the build selects CAS latency 3 (the default) and 0 for latency 2.
- R10: A reset in the middle of a run returns every output to its R1 value, and a later `init_start` runs the full sequence again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| init_start | input | 1 | Pulse that starts the sequence |
| bcast_done | input | 1 | Broadcaster reports the current command sent to all rows |
| bcast_req | output | 1 | Request to the broadcaster, held until acknowledged |
| cmd_code | output | 3 | Command to broadcast |
| cas_sel | output | 1 | CAS latency select (1 = latency 3) |
| refresh_en | output | 1 | Enables periodic refresh after initialization |
| init_done | output | 1 | Initialization complete |

## Verification
The bench measures every gap between an acknowledge and the next request, and it runs the sequence with two different acknowledge latencies. A timer started from the request instead of the acknowledge would shrink the gaps when the latency is nonzero, and a prescaler off by one would stretch the 200 µs wait by hundreds of cycles. The bench counts and decodes every accepted command, so a refresh loop that stops at seven or runs to nine shows up as a wrong count or order. The bench also does the following:
- it injects spurious acknowledges while the block is idle and during waits;
- it pulses start in the middle of a run and after completion;
- it resets the block partway through a run.

A design that lets any of these events disturb its state would shorten a wait, skip a step or restart the sequence.

// File: rtl/sdram_init_pkg.sv
package sdram_init_pkg;

    localparam int WAIT_W = 16;

    typedef logic [WAIT_W-1:0] wait_us_t;

    typedef enum logic [2:0] {
        CMD_NORMAL    = 3'b000,
        CMD_NOP       = 3'b001,
        CMD_PRECHARGE = 3'b010,
        CMD_MODESET   = 3'b011,
        CMD_REFRESH   = 3'b100
    } sdram_cmd_e;

    typedef enum logic [2:0] {
        PH_NOP     = 3'd0,
        PH_PRECHG  = 3'd1,
        PH_REFRESH = 3'd2,
        PH_MODESET = 3'd3,
        PH_NORMAL  = 3'd4
    } init_phase_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_WAIT  = 2'd2,
        ST_DONE  = 2'd3
    } seq_state_e;

    typedef struct packed {
        wait_us_t nop_us;
        wait_us_t prechg_us;
        wait_us_t refresh_us;
        wait_us_t modeset_us;
        wait_us_t normal_us;
    } wait_plan_t;

    function automatic sdram_cmd_e phase_cmd(input init_phase_e ph);
        case (ph)
            PH_NOP:     return CMD_NOP;
            PH_PRECHG:  return CMD_PRECHARGE;
            PH_REFRESH: return CMD_REFRESH;
            PH_MODESET: return CMD_MODESET;
            default:    return CMD_NORMAL;
        endcase
    endfunction

    function automatic wait_us_t phase_wait(input wait_plan_t p, input init_phase_e ph);
        case (ph)
            PH_NOP:     return p.nop_us;
            PH_PRECHG:  return p.prechg_us;
            PH_REFRESH: return p.refresh_us;
            PH_MODESET: return p.modeset_us;
            default:    return p.normal_us;
        endcase
    endfunction

    function automatic init_phase_e phase_after(input init_phase_e ph);
        case (ph)
            PH_NOP:     return PH_PRECHG;
            PH_PRECHG:  return PH_REFRESH;
            PH_REFRESH: return PH_MODESET;
            default:    return PH_NORMAL;
        endcase
    endfunction

endpackage

// File: rtl/sdram_us_tick.sv
module sdram_us_tick #(
    parameter int CLKS_PER_US = 100
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic tick
);

    generate
        if (CLKS_PER_US <= 1) begin : g_direct
            assign tick = run;
        end else begin : g_div
            localparam int CW = $clog2(CLKS_PER_US);
            localparam logic [CW-1:0] LAST = CW'(CLKS_PER_US - 1);

            logic [CW-1:0] cnt;

            always_ff @(posedge clk) begin
                if (rst || !run) begin
                    cnt <= '0;
                end else if (cnt == LAST) begin
                    cnt <= '0;
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end

            assign tick = run && (cnt == LAST);
        end
    endgenerate

endmodule

// File: rtl/sdram_wait_timer.sv
module sdram_wait_timer
    import sdram_init_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     load,
    input  wait_us_t load_us,
    input  logic     tick,
    output logic     active,
    output logic     expire
);

    wait_us_t left;

    always_ff @(posedge clk) begin
        if (rst) begin
            left <= '0;
        end else if (load) begin
            left <= load_us;
        end else if (tick && active) begin
            left <= left - 1'b1;
        end
    end

    assign active = (left != '0);
    assign expire = tick && (left == wait_us_t'(1));

endmodule

// File: rtl/sdram_step_fsm.sv
module sdram_step_fsm
    import sdram_init_pkg::*;
#(
    parameter int REFRESH_REPS = 8
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       init_start,
    input  logic       bcast_done,
    input  logic       wait_expire,
    input  wait_plan_t plan,
    output logic       bcast_req,
    output logic [2:0] cmd_code,
    output logic       timer_load,
    output wait_us_t   timer_us,
    output logic       in_wait,
    output logic       seq_done
);

    localparam int RW = (REFRESH_REPS > 1) ? $clog2(REFRESH_REPS) : 1;
    localparam logic [RW-1:0] REP_LAST = RW'(REFRESH_REPS - 1);

    seq_state_e  state, state_nx;
    init_phase_e phase, phase_nx;
    logic [RW-1:0] rep_cnt, rep_cnt_nx;

    always_comb begin
        state_nx   = state;
        phase_nx   = phase;
        rep_cnt_nx = rep_cnt;
        case (state)
            ST_IDLE: begin
                if (init_start) begin
                    state_nx   = ST_ISSUE;
                    phase_nx   = PH_NOP;
                    rep_cnt_nx = '0;
                end
            end
            ST_ISSUE: begin
                if (bcast_done) begin
                    state_nx = ST_WAIT;
                end
            end
            ST_WAIT: begin
                if (wait_expire) begin
                    if (phase == PH_REFRESH && rep_cnt != REP_LAST) begin
                        rep_cnt_nx = rep_cnt + 1'b1;
                        state_nx   = ST_ISSUE;
                    end else if (phase == PH_NORMAL) begin
                        state_nx = ST_DONE;
                    end else begin
                        phase_nx   = phase_after(phase);
                        rep_cnt_nx = '0;
                        state_nx   = ST_ISSUE;
                    end
                end
            end
            default: begin
                state_nx = ST_DONE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            phase   <= PH_NOP;
            rep_cnt <= '0;
        end else begin
            state   <= state_nx;
            phase   <= phase_nx;
            rep_cnt <= rep_cnt_nx;
        end
    end

    assign bcast_req  = (state == ST_ISSUE);
    assign cmd_code   = (state == ST_ISSUE) ? phase_cmd(phase) : CMD_NORMAL;
    assign timer_load = (state == ST_ISSUE) && bcast_done;
    assign timer_us   = phase_wait(plan, phase);
    assign in_wait    = (state == ST_WAIT);
    assign seq_done   = (state == ST_DONE);

endmodule

// File: rtl/sdram_pwrup_seq.sv
module sdram_pwrup_seq
    import sdram_init_pkg::*;
#(
    parameter int CLKS_PER_US     = 100,
    parameter int NOP_WAIT_US     = 200,
    parameter int PRECHG_WAIT_US  = 1,
    parameter int REFRESH_WAIT_US = 1,
    parameter int REFRESH_REPS    = 8,
    parameter int MODESET_WAIT_US = 2,
    parameter int NORMAL_WAIT_US  = 1,
    parameter int CAS_LAT3        = 1
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       init_start,
    input  logic       bcast_done,
    output logic       bcast_req,
    output logic [2:0] cmd_code,
    output logic       cas_sel,
    output logic       refresh_en,
    output logic       init_done
);

    localparam wait_plan_t PLAN = '{
        nop_us:     wait_us_t'(NOP_WAIT_US),
        prechg_us:  wait_us_t'(PRECHG_WAIT_US),
        refresh_us: wait_us_t'(REFRESH_WAIT_US),
        modeset_us: wait_us_t'(MODESET_WAIT_US),
        normal_us:  wait_us_t'(NORMAL_WAIT_US)
    };
    localparam logic CAS_BIT = (CAS_LAT3 != 0);

    logic     timer_load;
    wait_us_t timer_us;
    logic     timer_active;
    logic     us_tick;
    logic     wait_expire;
    logic     fsm_in_wait;
    logic     seq_done;

    sdram_step_fsm #(
        .REFRESH_REPS(REFRESH_REPS)
    ) fsm_i (
        .clk        (clk),
        .rst        (rst),
        .init_start (init_start),
        .bcast_done (bcast_done),
        .wait_expire(wait_expire),
        .plan       (PLAN),
        .bcast_req  (bcast_req),
        .cmd_code   (cmd_code),
        .timer_load (timer_load),
        .timer_us   (timer_us),
        .in_wait    (fsm_in_wait),
        .seq_done   (seq_done)
    );

    sdram_us_tick #(
        .CLKS_PER_US(CLKS_PER_US)
    ) tick_i (
        .clk (clk),
        .rst (rst),
        .run (timer_active),
        .tick(us_tick)
    );

    sdram_wait_timer timer_i (
        .clk    (clk),
        .rst    (rst),
        .load   (timer_load),
        .load_us(timer_us),
        .tick   (us_tick),
        .active (timer_active),
        .expire (wait_expire)
    );

    assign cas_sel    = CAS_BIT;
    assign refresh_en = seq_done;
    assign init_done  = seq_done;

endmodule

// File: rtl/sdram_pwrup_seq_chk.sv
module sdram_pwrup_seq_chk (
    input logic       clk,
    input logic       rst,
    input logic       bcast_req,
    input logic       bcast_done,
    input logic [2:0] cmd_code,
    input logic       refresh_en,
    input logic       init_done,
    input logic       timer_active,
    input logic       fsm_in_wait,
    input logic       wait_expire
);

    // R3
    req_hold_chk: assert property (@(posedge clk) disable iff (rst)
        bcast_req && !bcast_done |=> bcast_req && $stable(cmd_code));

    // R3
    req_drop_chk: assert property (@(posedge clk) disable iff (rst)
        bcast_req && bcast_done |=> !bcast_req);

    // R2
    cmd_legal_chk: assert property (@(posedge clk) disable iff (rst)
        bcast_req |-> cmd_code <= 3'b100);

    // R4
    expire_in_wait_chk: assert property (@(posedge clk) disable iff (rst)
        wait_expire |-> fsm_in_wait);

    // R4
    quiet_wait_chk: assert property (@(posedge clk) disable iff (rst)
        timer_active |-> !bcast_req);

    // R6
    done_after_wait_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(init_done) |-> $past(wait_expire));

    // R6
    refresh_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        refresh_en |-> !bcast_req && !timer_active);

    // R7
    done_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        init_done |=> init_done && refresh_en);

endmodule

bind sdram_pwrup_seq sdram_pwrup_seq_chk chk_i (
    .clk         (clk),
    .rst         (rst),
    .bcast_req   (bcast_req),
    .bcast_done  (bcast_done),
    .cmd_code    (cmd_code),
    .refresh_en  (refresh_en),
    .init_done   (init_done),
    .timer_active(timer_active),
    .fsm_in_wait (fsm_in_wait),
    .wait_expire (wait_expire)
);

// File: tb/sdram_pwrup_seq_tb_top.sv
module sdram_pwrup_seq_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int CPU        = 3;
    localparam int NCMD       = 12;
    localparam int SUM_US     = 212;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic init_start = 1'b0;
    logic bcast_done = 1'b0;
    logic bcast_req;
    logic [2:0] cmd_code;
    logic cas_sel;
    logic refresh_en;
    logic init_done;

    int n_checks = 0;
    int n_fail   = 0;
    int lat      = 0;
    bit stray_mode = 1'b0;
    int seq_id   = 0;

    sdram_pwrup_seq #(.CLKS_PER_US(CPU)) dut_i (
        .clk(clk), .rst(rst), .init_start(init_start), .bcast_done(bcast_done),
        .bcast_req(bcast_req), .cmd_code(cmd_code), .cas_sel(cas_sel),
        .refresh_en(refresh_en), .init_done(init_done)
    );

    initial forever #(CLK_PERIOD/2) clk = ~clk;

    // Broadcaster model
    int hold = 0;
    initial forever begin
        @(negedge clk);
        if (bcast_req) begin
            if (hold >= lat) begin bcast_done = 1'b1; hold = 0; end
            else begin bcast_done = 1'b0; hold++; end
        end else begin
            bcast_done = stray_mode;
            hold = 0;
        end
    end

    // Monitor
    int cyc = 0;
    int last_id = 0;
    int log_n = 0;
    logic [2:0] log_cmd [16];
    int done_c [16];
    int rise_c [16];
    int start_c = -1;
    int fin_c = -1;
    int ref_c = -1;
    int rise_total = 0;
    int mon_err = 0;
    logic prev_req = 1'b0;
    logic prev_pend = 1'b0;
    logic [2:0] prev_cmd = 3'b000;

    initial forever begin
        @(negedge clk);
        #1;
        cyc++;
        if (seq_id != last_id) begin
            last_id = seq_id; log_n = 0; start_c = -1; fin_c = -1; ref_c = -1;
        end
        if (!rst) begin
            if (init_start && start_c < 0) start_c = cyc;
            if (prev_pend && (!bcast_req || cmd_code != prev_cmd)) mon_err++;
            if (refresh_en && bcast_req) mon_err++;
            if (bcast_req && !prev_req) begin
                rise_total++;
                if (log_n < 16) rise_c[log_n] = cyc;
            end
            if (bcast_req && bcast_done && log_n < 16) begin
                log_cmd[log_n] = cmd_code; done_c[log_n] = cyc; log_n++;
            end
            if (init_done && fin_c < 0) fin_c = cyc;
            if (refresh_en && ref_c < 0) ref_c = cyc;
        end
        prev_req  = bcast_req && !rst;
        prev_pend = bcast_req && !bcast_done && !rst;
        prev_cmd  = cmd_code;
    end

    initial begin
        repeat (100000) @(posedge clk);
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks + 1, n_fail + 1);
        $finish;
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic int exp_wait(input int i);
        if (i == 0) return 200;
        if (i == 10) return 2;
        return 1;
    endfunction

    function automatic logic [2:0] exp_cmd(input int i);
        if (i == 0) return 3'b001;
        if (i == 1) return 3'b010;
        if (i == 10) return 3'b011;
        if (i == 11) return 3'b000;
        return 3'b100;
    endfunction

    task automatic do_reset();
        @(negedge clk); rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
    endtask

    task automatic pulse_start();
        @(negedge clk); init_start = 1'b1;
        @(negedge clk); init_start = 1'b0;
    endtask

    task automatic wait_log(input int n);
        for (int k = 0; k < 3000 && log_n < n; k++) @(negedge clk);
    endtask

    task automatic t_reset_state();
        do_reset();
        chk(!bcast_req, "R1 req after reset", int'(bcast_req), 0);
        chk(cmd_code == 3'b000, "R1 cmd after reset", int'(cmd_code), 0);
        chk(!refresh_en && !init_done, "R1 done/refresh after reset", int'(init_done), 0);
        chk(cas_sel == 1'b1, "R9 cas select", int'(cas_sel), 1);
        repeat (10) @(negedge clk);
        chk(!bcast_req, "R1 idle without start", int'(bcast_req), 0);
    endtask

    task automatic t_idle_stray();
        int r0;
        r0 = rise_total;
        stray_mode = 1'b1;
        repeat (15) @(negedge clk);
        stray_mode = 1'b0;
        repeat (2) @(negedge clk);
        chk(rise_total == r0 && !bcast_req, "R3 stray done while idle", rise_total - r0, 0);
        chk(!init_done, "R3 stray done no completion", int'(init_done), 0);
    endtask

    task automatic run_full(input int l, input bit st, input bit extra, input string tag);
        int cmd_err, gap_err, expect_total;
        lat = l; stray_mode = st; seq_id++;
        pulse_start();
        if (extra) begin
            wait_log(3);
            pulse_start();
        end
        for (int k = 0; k < 5000 && fin_c < 0; k++) @(negedge clk);
        stray_mode = 1'b0;
        @(negedge clk);
        cmd_err = 0; gap_err = 0;
        for (int i = 0; i < NCMD; i++) begin
            if (log_cmd[i] !== exp_cmd(i)) cmd_err++;
            if (i < NCMD - 1 && rise_c[i+1] - done_c[i] != exp_wait(i) * CPU + 1) gap_err++;
        end
        chk(log_n == NCMD, {"R2 command count ", tag}, log_n, NCMD);
        chk(cmd_err == 0, {"R2 command order ", tag}, cmd_err, 0);
        chk(rise_c[0] == start_c + 1, {"R2 first request timing ", tag}, rise_c[0] - start_c, 1);
        chk(gap_err == 0, {"R4 wait lengths ", tag}, gap_err, 0);
        expect_total = SUM_US * CPU + 13 + NCMD * l;
        chk(fin_c - start_c == expect_total, {"R5 total run time ", tag}, fin_c - start_c, expect_total);
        chk(fin_c == done_c[NCMD-1] + CPU + 1, {"R6 done after normal wait ", tag},
            fin_c - done_c[NCMD-1], CPU + 1);
        chk(ref_c == fin_c, {"R6 refresh with done ", tag}, ref_c, fin_c);
        chk(mon_err == 0, {"R3 request hold ", tag}, mon_err, 0);
        if (extra) chk(gap_err == 0 && log_n == NCMD, "R8 start during run ignored", log_n, NCMD);
    endtask

    task automatic t_after_done();
        int r0;
        r0 = rise_total;
        pulse_start();
        repeat (20) @(negedge clk);
        pulse_start();
        repeat (5) @(negedge clk);
        chk(rise_total == r0, "R8 start after completion", rise_total - r0, 0);
        chk(init_done && refresh_en, "R7 done sticky", int'(init_done), 1);
        chk(!bcast_req, "R7 no request after done", int'(bcast_req), 0);
    endtask

    task automatic t_reset_mid();
        lat = 1; seq_id++;
        pulse_start();
        wait_log(5);
        do_reset();
        chk(!bcast_req && cmd_code == 3'b000, "R10 req/cmd after mid reset", int'(bcast_req), 0);
        chk(!init_done && !refresh_en, "R10 done after mid reset", int'(init_done), 0);
        run_full(2, 1'b0, 1'b0, "R10 restart");
    endtask

    initial begin
        t_reset_state();
        t_idle_stray();
        run_full(0, 1'b0, 1'b0, "lat0");
        t_after_done();
        do_reset();
        run_full(3, 1'b1, 1'b1, "lat3 stray");
        t_after_done();
        t_reset_mid();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule